// File: doc/BRIEF.md
# Peripheral Channel Error Reporter

This block records errors seen on the peripheral channel of a host controller and turns them into sideband message requests. Every error event comes with a class (fatal, non-fatal, received abort or unsupported request) and a 4-bit cause code. Fatal and non-fatal errors set sticky status bits and capture a cause code. Each routable class has its own 2-bit routing field. That field either drops the report, sends it as a system-error request, or raises a system management interrupt (SMI).

Software reaches the block through one write port that carries a data word and a bit mask. With the same port, software sets the routing fields and clears the status bits by writing 1 to them. The current state shows on a register view port, and each logged class has its own cause output. Message requests wait in a three-entry pending set. They leave one per cycle through a valid/ready handshake, ordered by a fixed priority.

Top module: `pc_err_report`

Register view and write layout (REG_W = 16): bits 1:0 fatal route, 3:2 non-fatal route, 5:4 abort route, 6 unsupported-request report enable, 8 fatal status, 9 non-fatal status, 10 unsupported-request detected, 11 signaled system error. Bits 7 and 15:12 read as 0.

## Requirements
- R1: A routing field value of 2'b10 sends a system-error request, and only while sys_err_en is 1 and host_in_reset is 0. A value of 2'b11 sends an assert-SMI request while host_in_reset is 0. Values 2'b00 and 2'b01 send nothing. Event class codes are 0 fatal, 1 non-fatal, 2 received abort, 3 unsupported request.
- R2: A fatal or non-fatal event sets that class's status bit (view bit 8 or 9) on the next clock edge, whatever the routing field holds. Writing 1 with mask 1 to the bit clears it.
- R3: A class's cause output takes ev_cause when an event of that class arrives while its status bit is 0. While the status bit is 1, the cause output holds its value.
- R4: A write that clears a fatal or non-fatal status bit that is 1 queues a deassert-SMI request, provided that class routes 2'b11 and host_in_reset is 0.
- R5: Any system-error request sets the signaled-system-error bit (view bit 11). That bit is cleared by a write of 1 and is never set while sys_err_en is 0.
- R6: While host_in_reset is 1, no request of any kind is queued. Status bits and cause codes are still logged.
- R7: A posted unsupported request (ev_posted=1) sets view bit 10 when bit 6 is 1. If sys_err_en is also 1 and host_in_reset is 0, it also queues a system-error request. A non-posted unsupported request changes nothing and queues nothing.
- R8: A received-abort event queues a request according to the abort routing field and changes no status bit.
- R9: msg_valid is 1 while any request is pending. msg_type is 3 for deassert-SMI, 2 for assert-SMI and 1 for system-error, in that order of priority. One request is removed per cycle in which msg_valid and msg_ready are both 1. A request of a kind that is already pending merges with it.
- R10: After rst_n is low, the register view, both cause outputs and msg_valid are 0.
- R11: A hardware set of a status bit wins over a software clear in the same cycle. No deassert-SMI is queued in that case.
- R12: A write changes only the routing and enable bits whose mask bit is 1. Status bits change only through a clear, and read-only bits stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| host_in_reset | input | 1 | Host held in platform reset |
| sys_err_en | input | 1 | Global system-error enable |
| ev_valid | input | 1 | Error event strobe |
| ev_class | input | 2 | Event class code |
| ev_cause | input | CAUSE_W | Event cause code |
| ev_posted | input | 1 | Event came from a posted request |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | REG_W | Write data |
| wr_mask | input | REG_W | Write bit mask |
| reg_view | output | REG_W | Routing, enable and status bits |
| fatal_cause | output | CAUSE_W | Logged fatal cause |
| nonfatal_cause | output | CAUSE_W | Logged non-fatal cause |
| msg_valid | output | 1 | A message request is offered |
| msg_type | output | 2 | Kind of the offered request |
| msg_ready | input | 1 | Sideband accepts the request |

## Verification
The bench goes after collisions. In one case a status clear lands in the same cycle as a new event of that class. A design that let the clear win would lose the error and send a false deassert-SMI. Cause capture is checked against an already-set status bit, since a design that does not lock the field would overwrite the first cause. Other cases cover host reset, non-posted unsupported requests, the reserved routing code and system-error routing with the global enable off. A leak in any of these would show up as an extra message. Several request kinds are left pending behind a stalled msg_ready, so a wrong priority or a dropped merge shows up in the msg_type order.

// File: rtl/pc_err_pkg.sv
package pc_err_pkg;
    localparam int unsigned ROUTE_W = 2;
    localparam int unsigned N_CLASS = 4;

    localparam logic [ROUTE_W-1:0] ROUTE_SERR = 2'b10;
    localparam logic [ROUTE_W-1:0] ROUTE_SMI  = 2'b11;

    // class codes on ev_class
    localparam logic [1:0] CLS_FATAL    = 2'd0;
    localparam logic [1:0] CLS_NONFATAL = 2'd1;
    localparam logic [1:0] CLS_ABORT    = 2'd2;
    localparam logic [1:0] CLS_UNSUP    = 2'd3;

    // register view bit positions
    localparam int unsigned BIT_ROUTE_BASE = 0;
    localparam int unsigned BIT_UR_EN      = 6;
    localparam int unsigned BIT_LOG_BASE   = 8;
    localparam int unsigned BIT_UR_DET     = 10;
    localparam int unsigned BIT_SSE        = 11;

    // pending-set index: a higher index drains first; msg_type = index + 1
    localparam int unsigned Q_SERR    = 0;
    localparam int unsigned Q_SMI_ON  = 1;
    localparam int unsigned Q_SMI_OFF = 2;
endpackage

// File: rtl/pc_err_route.sv
module pc_err_route
    import pc_err_pkg::*;
(
    input  logic [ROUTE_W-1:0] route_i,
    input  logic               fire_i,
    input  logic               sys_err_en_i,
    input  logic               host_rst_i,
    output logic               serr_o,
    output logic               smi_o
);
    always_comb begin
        serr_o = fire_i && !host_rst_i && sys_err_en_i && (route_i == ROUTE_SERR);
        smi_o  = fire_i && !host_rst_i && (route_i == ROUTE_SMI);
    end
endmodule

// File: rtl/pc_err_class_log.sv
module pc_err_class_log #(
    parameter int unsigned CAUSE_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hit_i,
    input  logic [CAUSE_W-1:0] cause_i,
    input  logic               clr_i,
    output logic               sts_o,
    output logic [CAUSE_W-1:0] cause_o,
    output logic               cleared_o
);
    typedef struct packed {
        logic               sts;
        logic [CAUSE_W-1:0] cause;
    } log_t;

    log_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        cleared_o = 1'b0;
        if (hit_i) begin
            if (!st_q.sts) st_d.cause = cause_i;
            st_d.sts = 1'b1;
        end else if (clr_i && st_q.sts) begin
            st_d.sts  = 1'b0;
            cleared_o = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sts_o   = st_q.sts;
    assign cause_o = st_q.cause;

    assert_sticky_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        hit_i |=> sts_o);

    assert_cause_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sts_o |=> $stable(cause_o));
endmodule

// File: rtl/pc_err_msg_q.sv
module pc_err_msg_q #(
    parameter int unsigned N_KIND = 3,
    parameter int unsigned KIND_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_KIND-1:0] push_i,
    input  logic              ready_i,
    output logic              valid_o,
    output logic [KIND_W-1:0] kind_o
);
    typedef struct packed {
        logic [N_KIND-1:0] pend;
    } q_t;

    q_t q_d, q_q;
    logic [N_KIND-1:0] sel;
    logic [N_KIND-1:0] drain;

    always_comb begin
        sel    = '0;
        kind_o = '0;
        for (int i = 0; i < N_KIND; i++) begin
            if (q_q.pend[i]) begin
                sel    = '0;
                sel[i] = 1'b1;
                kind_o = KIND_W'(i + 1);
            end
        end
        valid_o  = |q_q.pend;
        drain    = (valid_o && ready_i) ? sel : '0;
        q_d.pend = (q_q.pend & ~drain) | push_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    assert_hold_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !ready_i) |=> valid_o);

    assert_no_demote_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !ready_i) |=> (kind_o >= $past(kind_o)));
endmodule

// File: rtl/pc_err_report.sv
module pc_err_report
    import pc_err_pkg::*;
#(
    parameter int unsigned CAUSE_W = 4,
    parameter int unsigned REG_W   = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_in_reset,
    input  logic               sys_err_en,
    input  logic               ev_valid,
    input  logic [1:0]         ev_class,
    input  logic [CAUSE_W-1:0] ev_cause,
    input  logic               ev_posted,
    input  logic               wr_en,
    input  logic [REG_W-1:0]   wr_data,
    input  logic [REG_W-1:0]   wr_mask,
    output logic [REG_W-1:0]   reg_view,
    output logic [CAUSE_W-1:0] fatal_cause,
    output logic [CAUSE_W-1:0] nonfatal_cause,
    output logic               msg_valid,
    output logic [1:0]         msg_type,
    input  logic               msg_ready
);
    localparam int unsigned N_LOG = 2;  // fatal, non-fatal
    localparam int unsigned N_RT  = 3;  // fatal, non-fatal, abort
    localparam int unsigned N_MSG = 3;

    typedef struct packed {
        logic [N_RT-1:0][ROUTE_W-1:0] route;
        logic                         ur_en;
        logic                         ur_det;
        logic                         sse;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [N_CLASS-1:0]            hit;
    logic [REG_W-1:0]              wr_clr;
    logic [N_LOG-1:0]              log_sts;
    logic [N_LOG-1:0]              log_clr;
    logic [N_LOG-1:0][CAUSE_W-1:0] log_cause;
    logic [N_LOG-1:0]              smi_off;
    logic [N_RT-1:0]               rt_serr;
    logic [N_RT-1:0]               rt_smi;
    logic                          ur_hit;
    logic                          ur_serr;
    logic [N_MSG-1:0]              push;

    always_comb begin
        for (int i = 0; i < N_CLASS; i++) begin
            hit[i] = ev_valid && (ev_class == 2'(i));
        end
        wr_clr = wr_en ? (wr_data & wr_mask) : '0;
    end

    for (genvar g = 0; g < N_LOG; g++) begin : g_log
        pc_err_class_log #(.CAUSE_W(CAUSE_W)) u_log (
            .clk       (clk),
            .rst_n     (rst_n),
            .hit_i     (hit[g]),
            .cause_i   (ev_cause),
            .clr_i     (wr_clr[BIT_LOG_BASE + g]),
            .sts_o     (log_sts[g]),
            .cause_o   (log_cause[g]),
            .cleared_o (log_clr[g])
        );
        assign smi_off[g] = log_clr[g] && (ctl_q.route[g] == ROUTE_SMI) && !host_in_reset;
    end

    for (genvar g = 0; g < N_RT; g++) begin : g_route
        pc_err_route u_rt (
            .route_i      (ctl_q.route[g]),
            .fire_i       (hit[g]),
            .sys_err_en_i (sys_err_en),
            .host_rst_i   (host_in_reset),
            .serr_o       (rt_serr[g]),
            .smi_o        (rt_smi[g])
        );
    end

    always_comb begin
        ur_hit  = hit[CLS_UNSUP] && ev_posted && ctl_q.ur_en;
        ur_serr = ur_hit && sys_err_en && !host_in_reset;

        push            = '0;
        push[Q_SERR]    = (|rt_serr) || ur_serr;
        push[Q_SMI_ON]  = |rt_smi;
        push[Q_SMI_OFF] = |smi_off;

        ctl_d = ctl_q;
        if (wr_en) begin
            for (int r = 0; r < N_RT; r++) begin
                for (int k = 0; k < ROUTE_W; k++) begin
                    if (wr_mask[BIT_ROUTE_BASE + r*ROUTE_W + k])
                        ctl_d.route[r][k] = wr_data[BIT_ROUTE_BASE + r*ROUTE_W + k];
                end
            end
            if (wr_mask[BIT_UR_EN]) ctl_d.ur_en = wr_data[BIT_UR_EN];
        end
        if (ur_hit)                  ctl_d.ur_det = 1'b1;
        else if (wr_clr[BIT_UR_DET]) ctl_d.ur_det = 1'b0;
        if (push[Q_SERR])            ctl_d.sse = 1'b1;
        else if (wr_clr[BIT_SSE])    ctl_d.sse = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    pc_err_msg_q #(.N_KIND(N_MSG), .KIND_W(2)) u_q (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (push),
        .ready_i (msg_ready),
        .valid_o (msg_valid),
        .kind_o  (msg_type)
    );

    always_comb begin
        reg_view = '0;
        for (int r = 0; r < N_RT; r++) begin
            reg_view[BIT_ROUTE_BASE + r*ROUTE_W +: ROUTE_W] = ctl_q.route[r];
        end
        reg_view[BIT_UR_EN]              = ctl_q.ur_en;
        reg_view[BIT_LOG_BASE +: N_LOG]  = log_sts;
        reg_view[BIT_UR_DET]             = ctl_q.ur_det;
        reg_view[BIT_SSE]                = ctl_q.sse;
        fatal_cause    = log_cause[0];
        nonfatal_cause = log_cause[1];
    end

    assert_sse_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reg_view[BIT_SSE]) |-> $past(sys_err_en && !host_in_reset));

    assert_quiet_in_reset_R6: assert property (@(posedge clk) disable iff (!rst_n)
        host_in_reset |-> (push == '0));

    assert_np_unsup_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && ev_class == CLS_UNSUP && !ev_posted && !wr_clr[BIT_UR_DET])
        |=> (reg_view[BIT_UR_DET] == $past(reg_view[BIT_UR_DET])));
endmodule

// File: tb/pc_err_report_tb_top.sv
module pc_err_report_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_in_reset = 1'b0;
    logic        sys_err_en = 1'b0;
    logic        ev_valid = 1'b0;
    logic [1:0]  ev_class = 2'd0;
    logic [3:0]  ev_cause = 4'd0;
    logic        ev_posted = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] wr_mask = '0;
    logic [15:0] reg_view;
    logic [3:0]  fatal_cause;
    logic [3:0]  nonfatal_cause;
    logic        msg_valid;
    logic [1:0]  msg_type;
    logic        msg_ready = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    pc_err_report dut_i (
        .clk(clk), .rst_n(rst_n), .host_in_reset(host_in_reset), .sys_err_en(sys_err_en),
        .ev_valid(ev_valid), .ev_class(ev_class), .ev_cause(ev_cause), .ev_posted(ev_posted),
        .wr_en(wr_en), .wr_data(wr_data), .wr_mask(wr_mask),
        .reg_view(reg_view), .fatal_cause(fatal_cause), .nonfatal_cause(nonfatal_cause),
        .msg_valid(msg_valid), .msg_type(msg_type), .msg_ready(msg_ready)
    );

    // reference model state
    logic [1:0] m_rt [3];
    logic       m_uren, m_urdet, m_sse;
    logic [1:0] m_sts;
    logic [3:0] m_cause [2];
    logic [2:0] m_pend;

    function automatic logic [15:0] exp_view();
        logic [15:0] v;
        v = '0;
        v[1:0] = m_rt[0]; v[3:2] = m_rt[1]; v[5:4] = m_rt[2];
        v[6] = m_uren; v[9:8] = m_sts; v[10] = m_urdet; v[11] = m_sse;
        return v;
    endfunction

    function automatic logic [1:0] exp_type();
        if (m_pend[2]) return 2'd3;
        if (m_pend[1]) return 2'd2;
        if (m_pend[0]) return 2'd1;
        return 2'd0;
    endfunction

    function automatic logic wclr(input int b);
        return wr_en && wr_mask[b] && wr_data[b];
    endfunction

    task automatic model_reset();
        for (int c = 0; c < 3; c++) m_rt[c] = 2'b00;
        m_uren = 0; m_urdet = 0; m_sse = 0; m_sts = '0;
        m_cause[0] = '0; m_cause[1] = '0; m_pend = '0;
    endtask

    task automatic model_step();
        logic [2:0] push;
        logic [2:0] drain;
        logic [3:0] hitv;
        logic       ur_set;
        push = '0; drain = '0; ur_set = 0;
        for (int c = 0; c < 4; c++) hitv[c] = ev_valid && (ev_class == 2'(c));
        for (int c = 0; c < 3; c++) begin
            if (hitv[c] && !host_in_reset) begin
                if (m_rt[c] == 2'b10 && sys_err_en) push[0] = 1;
                if (m_rt[c] == 2'b11) push[1] = 1;
            end
        end
        if (hitv[3] && ev_posted && m_uren) begin
            ur_set = 1;
            if (sys_err_en && !host_in_reset) push[0] = 1;
        end
        for (int c = 0; c < 2; c++) begin
            if (wclr(8 + c) && m_sts[c] && !hitv[c] && m_rt[c] == 2'b11 && !host_in_reset)
                push[2] = 1;
        end
        if (msg_ready) begin
            if (m_pend[2]) drain = 3'b100;
            else if (m_pend[1]) drain = 3'b010;
            else if (m_pend[0]) drain = 3'b001;
        end
        for (int c = 0; c < 2; c++) begin
            if (hitv[c]) begin
                if (!m_sts[c]) m_cause[c] = ev_cause;
                m_sts[c] = 1;
            end else if (wclr(8 + c)) m_sts[c] = 0;
        end
        if (ur_set) m_urdet = 1; else if (wclr(10)) m_urdet = 0;
        if (push[0]) m_sse = 1; else if (wclr(11)) m_sse = 0;
        if (wr_en) begin
            for (int c = 0; c < 3; c++)
                for (int k = 0; k < 2; k++)
                    if (wr_mask[c*2 + k]) m_rt[c][k] = wr_data[c*2 + k];
            if (wr_mask[6]) m_uren = wr_data[6];
        end
        m_pend = (m_pend & ~drain) | push;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic compare(input string tag);
        chk({tag, " R12 reg_view"}, 32'(reg_view), 32'(exp_view()));
        chk({tag, " R3 fatal_cause"}, 32'(fatal_cause), 32'(m_cause[0]));
        chk({tag, " R3 nonfatal_cause"}, 32'(nonfatal_cause), 32'(m_cause[1]));
        chk({tag, " R9 msg_valid"}, 32'(msg_valid), 32'(|m_pend));
        chk({tag, " R9 msg_type"}, 32'(msg_type), 32'(exp_type()));
    endtask

    task automatic idle_inputs();
        ev_valid = 0; wr_en = 0; wr_data = '0; wr_mask = '0; ev_posted = 0;
    endtask

    // inputs already driven (at a negedge); model the edge, then check
    task automatic step(input string tag);
        model_step();
        @(negedge clk);
        compare(tag);
        idle_inputs();
    endtask

    task automatic ev(input logic [1:0] cls, input logic [3:0] cause, input logic posted, input string tag);
        ev_valid = 1; ev_class = cls; ev_cause = cause; ev_posted = posted;
        step(tag);
    endtask

    task automatic wr(input logic [15:0] d, input logic [15:0] m, input string tag);
        wr_en = 1; wr_data = d; wr_mask = m;
        step(tag);
    endtask

    task automatic drain_all();
        msg_ready = 1;
        for (int i = 0; i < 4; i++) step("R9 drain");
        msg_ready = 0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL R9 watchdog actual=timeout expected=finish");
            summary();
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        compare("R10 in reset");
        rst_n = 1;
        @(negedge clk);
        compare("R10 after reset");
        chk("R10 msg_valid", 32'(msg_valid), 0);

        sys_err_en = 1;
        // fatal->SMI, nonfatal->SERR, abort->reserved, UR reporting on
        wr(16'h005B, 16'h007F, "R12 cfg");
        chk("R12 view", 32'(reg_view), 32'h005B);
        ev(2'd0, 4'h8, 0, "R2 fatal");
        chk("R1 smi pending", 32'(msg_type), 2);
        chk("R3 first cause", 32'(fatal_cause), 8);
        ev(2'd1, 4'h3, 0, "R1 nonfatal serr");
        chk("R9 assert before serr", 32'(msg_type), 2);
        chk("R5 sse set", 32'(reg_view[11]), 1);
        ev(2'd0, 4'h9, 0, "R3 locked");
        chk("R3 cause held", 32'(fatal_cause), 8);
        ev(2'd2, 4'h1, 0, "R1 reserved route");
        wr(16'h0100, 16'h0100, "R4 clear fatal");
        chk("R4 deassert first", 32'(msg_type), 3);
        chk("R2 fatal cleared", 32'(reg_view[8]), 0);
        msg_ready = 1;
        step("R9 drain off");
        chk("R9 then assert", 32'(msg_type), 2);
        step("R9 drain on");
        chk("R9 then serr", 32'(msg_type), 1);
        step("R9 drain serr");
        chk("R9 empty", 32'(msg_valid), 0);
        msg_ready = 0;

        // R11: set and clear in one cycle
        ev_valid = 1; ev_class = 2'd0; ev_cause = 4'hA; wr_en = 1; wr_data = 16'h0100; wr_mask = 16'h0100;
        step("R11 set vs clear");
        ev_valid = 1; ev_class = 2'd0; ev_cause = 4'h9; wr_en = 1; wr_data = 16'h0100; wr_mask = 16'h0100;
        step("R11 set wins");
        chk("R11 status kept", 32'(reg_view[8]), 1);
        chk("R11 cause kept", 32'(fatal_cause), 32'hA);
        chk("R11 no deassert", 32'(msg_type), 2);
        wr(16'h0F00, 16'h0F00, "R2 clear all");
        drain_all();

        // R6: host in reset
        host_in_reset = 1;
        ev(2'd0, 4'h9, 0, "R6 fatal logged");
        ev(2'd1, 4'h5, 0, "R6 nonfatal logged");
        ev(2'd3, 4'h4, 1, "R6 unsup posted");
        chk("R6 no message", 32'(msg_valid), 0);
        chk("R6 status logged", 32'(reg_view[9:8]), 3);
        wr(16'h0100, 16'h0100, "R6 clear in reset");
        chk("R6 no deassert", 32'(msg_valid), 0);
        host_in_reset = 0;
        wr(16'h0F00, 16'h0F00, "R2 clear all");

        // R7: unsupported requests
        ev(2'd3, 4'h4, 0, "R7 non-posted");
        chk("R7 np no detect", 32'(reg_view[10]), 0);
        chk("R7 np no msg", 32'(msg_valid), 0);
        ev(2'd3, 4'h4, 1, "R7 posted");
        chk("R7 detect", 32'(reg_view[10]), 1);
        chk("R7 serr", 32'(msg_type), 1);
        drain_all();
        wr(16'h0C00, 16'h0C00, "R5 clear sse");
        sys_err_en = 0;
        ev(2'd3, 4'h4, 1, "R7 no global enable");
        ev(2'd1, 4'h2, 0, "R1 serr gated");
        chk("R5 sse stays 0", 32'(reg_view[11]), 0);
        chk("R1 gated no msg", 32'(msg_valid), 0);
        sys_err_en = 1;

        // R8: abort routed to SMI
        wr(16'h0F30, 16'h0F30, "R8 cfg abort smi");
        ev(2'd2, 4'h1, 0, "R8 abort");
        chk("R8 assert msg", 32'(msg_type), 2);
        chk("R8 no status", 32'(reg_view[11:8]), 0);
        drain_all();

        // random phase
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < 4000; i++) begin
            ev_valid = ($urandom_range(0, 1) == 1);
            ev_class = 2'($urandom_range(0, 3));
            ev_cause = 4'($urandom_range(1, 10));
            ev_posted = ($urandom_range(0, 1) == 1);
            wr_en = ($urandom_range(0, 3) == 0);
            wr_data = 16'($urandom);
            wr_mask = 16'($urandom);
            sys_err_en = ($urandom_range(0, 3) != 0);
            host_in_reset = ($urandom_range(0, 9) == 0);
            msg_ready = ($urandom_range(0, 4) < 3);
            step("R2 random");
        end

        finished = 1;
        summary();
        $finish;
    end
endmodule